// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the internal array addresses for a burst read from a synchronous memory. A start address and a set of burst options are captured on a one-cycle address-valid strobe. After an initial latency the block issues one address per beat, stepping through an aligned group of 4, 8, 16 or 32 locations in either linear (count-up with wrap) or interleaved (start XOR beat index) order. It marks the first cycle of each beat with a data-valid strobe.

The burst never ends by itself. It keeps cycling through its group until a new strobe restarts it or reset returns it to idle. While beats are running, a pause input freezes the address and the beat timing. The pause source is either a dedicated advance-hold input or the output-enable input, as chosen by a configuration bit. Addresses are counted in bus-width units: in 16-bit mode bit 0 of the address is the half-word bit, and in 32-bit mode bit 0 is the lowest word bit.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `beat_valid` is 0 and `arr_addr` is 0, even in the middle of a burst.
- R2: If `addr_valid` is high in cycle c, the first `beat_valid` appears in cycle c+3 when `cfg_lat5`=0 (four-clock latency, counting cycle c as clock 1), or in cycle c+4 when `cfg_lat5`=1. That first beat carries the start address.
- R3: Later beats start 1 cycle apart when `cfg_beat2`=0 and 2 cycles apart when `cfg_beat2`=1. `beat_valid` is high only in the first cycle of each beat, and `arr_addr` holds for the whole beat.
- R4: In linear order, offset k of the burst is (start + k) modulo the group size. A start of 2 in a 4-group gives 2, 3, 0, 1.
- R5: In interleaved order (`cfg_ilv`=1), offset k is start XOR k. A start of 1 gives 1, 0, 3, 2, and a start of 3 gives 3, 2, 1, 0.
- R6: Interleaved order is taken only when `cfg_wrap`=0 and `cfg_bus16`=1. Any other combination with `cfg_ilv`=1 runs in linear order.
- R7: `cfg_wrap` encodes the group size: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32. The address bits above the group offset stay equal to those of the start address. All `cfg_*` inputs are captured on the strobe.
- R8: The burst keeps cycling through its group after the first pass, with no gap in the beat timing.
- R9: With `cfg_sel_adv`=1, a high `adv_hold` sampled at a clock edge during beats stops the advance. `beat_valid` is then low and `arr_addr` is held until `adv_hold` falls, after which the next beat follows at the next edge. `oe_n` has no effect in this mode.
- R10: With `cfg_sel_adv`=0, `oe_n` takes the pause role described in R9 and `adv_hold` has no effect.
- R11: A strobe during a burst aborts it. `beat_valid` is low in the following cycle, and the new start address appears after the full initial latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Strobe that captures start address and options |
| start_addr | input | ADDR_W | Start address in bus-width units |
| cfg_wrap | input | 2 | Group size code (4/8/16/32) |
| cfg_ilv | input | 1 | Request interleaved order |
| cfg_bus16 | input | 1 | 1 = 16-bit bus mode |
| cfg_lat5 | input | 1 | 1 = five-clock initial latency, 0 = four |
| cfg_beat2 | input | 1 | 1 = two clocks per beat, 0 = one |
| cfg_sel_adv | input | 1 | Pause source: 1 = adv_hold, 0 = oe_n |
| adv_hold | input | 1 | Pause input when selected (high pauses) |
| oe_n | input | 1 | Output enable, active low; pauses when high and selected |
| arr_addr | output | ADDR_W | Current array address |
| beat_valid | output | 1 | High in the first cycle of each beat |

## Verification
The situation hardest to reach from the ports is a pause or a restart that lands exactly on a beat boundary, after some beats have gone out, with the pause source of the other mode held active at the same time. The stimulus waits for a chosen `beat_valid`, then in that same cycle raises the selected pause input while the unselected one stays asserted. It then checks that address and strobe freeze and that the following beat resumes one edge after release. Wrap behaviour is reached by starts placed near the top of each group size, and a long run in a 4-group takes the sequence through more than two passes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFS_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_BEAT = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        WRAP_4  = 2'd0,
        WRAP_8  = 2'd1,
        WRAP_16 = 2'd2,
        WRAP_32 = 2'd3
    } wrap_e;

    typedef struct packed {
        wrap_e wrap;
        logic  ilv;
        logic  beat2;
        logic  sel_adv;
    } burst_cfg_t;

    function automatic logic [OFS_W-1:0] wrap_mask(input wrap_e w);
        logic [OFS_W:0] span;
        span = (OFS_W+1)'(1) << (int'(w) + 2);
        return OFS_W'(span - (OFS_W+1)'(1));
    endfunction

    function automatic logic ilv_legal(input wrap_e w, input logic bus16);
        return (w == WRAP_4) && bus16;
    endfunction

    function automatic logic [OFS_W-1:0] beat_ofs(
        input logic [OFS_W-1:0] s,
        input logic [OFS_W-1:0] k,
        input logic             ilv,
        input logic [OFS_W-1:0] mask
    );
        logic [OFS_W-1:0] raw;
        raw = ilv ? (s ^ k) : (s + k);
        return raw & mask;
    endfunction

endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_in,
    input  logic [1:0]        wrap_in,
    input  logic              ilv_in,
    input  logic              bus16_in,
    input  logic              beat2_in,
    input  logic              sel_adv_in,
    output logic [ADDR_W-1:0] start_q,
    output burst_cfg_t        cfg_q
);

    burst_cfg_t cfg_d;

    always_comb begin
        cfg_d.wrap    = wrap_e'(wrap_in);
        cfg_d.ilv     = ilv_in && ilv_legal(wrap_e'(wrap_in), bus16_in);
        cfg_d.beat2   = beat2_in;
        cfg_d.sel_adv = sel_adv_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            cfg_q   <= '{wrap: WRAP_4, ilv: 1'b0, beat2: 1'b0, sel_adv: 1'b0};
        end else if (load) begin
            start_q <= start_in;
            cfg_q   <= cfg_d;
        end
    end

endmodule

// File: rtl/burst_timing_ctl.sv
module burst_timing_ctl
    import burst_seq_pkg::*;
#(
    parameter int LAT_A  = 4,
    parameter int LAT_B  = 5,
    parameter int BEAT_A = 1,
    parameter int BEAT_B = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic lat_long,
    input  logic beat_long,
    input  logic pause,
    output logic adv,
    output logic in_beat,
    output logic beat_valid
);

    localparam int CNT_W = $clog2(LAT_B);
    localparam int PH_W  = $clog2(BEAT_B + 1);
    localparam logic [CNT_W-1:0] CNT_A = CNT_W'(LAT_A - 3);
    localparam logic [CNT_W-1:0] CNT_B = CNT_W'(LAT_B - 3);
    localparam logic [PH_W-1:0]  PH_A  = PH_W'(BEAT_A - 1);
    localparam logic [PH_W-1:0]  PH_B  = PH_W'(BEAT_B - 1);

    seq_st_e          st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  ph_last;

    assign ph_last = beat_long ? PH_B : PH_A;
    assign in_beat = (st_q == ST_BEAT);
    assign adv     = in_beat && !pause && (ph_q == ph_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            ph_q       <= '0;
            beat_valid <= 1'b0;
        end else if (load) begin
            st_q       <= ST_LAT;
            cnt_q      <= lat_long ? CNT_B : CNT_A;
            ph_q       <= '0;
            beat_valid <= 1'b0;
        end else begin
            unique case (st_q)
                ST_LAT: begin
                    if (cnt_q == '0) begin
                        st_q       <= ST_BEAT;
                        ph_q       <= '0;
                        beat_valid <= 1'b1;
                    end else begin
                        cnt_q      <= cnt_q - CNT_W'(1);
                        beat_valid <= 1'b0;
                    end
                end
                ST_BEAT: begin
                    beat_valid <= adv;
                    if (!pause) begin
                        ph_q <= (ph_q == ph_last) ? '0 : ph_q + PH_W'(1);
                    end
                end
                default: begin
                    beat_valid <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] start_q,
    input  burst_cfg_t        cfg_q,
    output logic [ADDR_W-1:0] arr_addr
);

    logic [OFS_W-1:0] k_q;
    logic [OFS_W-1:0] mask;
    logic [OFS_W-1:0] ofs;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            k_q <= '0;
        end else if (adv) begin
            k_q <= k_q + OFS_W'(1);
        end
    end

    always_comb begin
        mask     = wrap_mask(cfg_q.wrap);
        ofs      = beat_ofs(start_q[OFS_W-1:0], k_q, cfg_q.ilv, mask);
        arr_addr = {start_q[ADDR_W-1:OFS_W], (start_q[OFS_W-1:0] & ~mask) | ofs};
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LAT_A  = 4,
    parameter int LAT_B  = 5,
    parameter int BEAT_A = 1,
    parameter int BEAT_B = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        cfg_wrap,
    input  logic              cfg_ilv,
    input  logic              cfg_bus16,
    input  logic              cfg_lat5,
    input  logic              cfg_beat2,
    input  logic              cfg_sel_adv,
    input  logic              adv_hold,
    input  logic              oe_n,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              beat_valid
);

    logic [ADDR_W-1:0] start_q;
    burst_cfg_t        cfg_q;
    logic              pause;
    logic              adv;
    logic              in_beat;

    assign pause = cfg_q.sel_adv ? adv_hold : oe_n;

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk        (clk),
        .rst        (rst),
        .load       (addr_valid),
        .start_in   (start_addr),
        .wrap_in    (cfg_wrap),
        .ilv_in     (cfg_ilv),
        .bus16_in   (cfg_bus16),
        .beat2_in   (cfg_beat2),
        .sel_adv_in (cfg_sel_adv),
        .start_q    (start_q),
        .cfg_q      (cfg_q)
    );

    burst_timing_ctl #(
        .LAT_A (LAT_A),
        .LAT_B (LAT_B),
        .BEAT_A(BEAT_A),
        .BEAT_B(BEAT_B)
    ) u_timing (
        .clk        (clk),
        .rst        (rst),
        .load       (addr_valid),
        .lat_long   (cfg_lat5),
        .beat_long  (cfg_q.beat2),
        .pause      (pause),
        .adv        (adv),
        .in_beat    (in_beat),
        .beat_valid (beat_valid)
    );

    burst_order_gen #(.ADDR_W(ADDR_W)) u_order (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_valid),
        .adv      (adv),
        .start_q  (start_q),
        .cfg_q    (cfg_q),
        .arr_addr (arr_addr)
    );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_valid,
    input logic              cfg_sel_adv,
    input logic              cfg_beat2,
    input logic              adv_hold,
    input logic              oe_n,
    input logic              in_beat,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              beat_valid
);

    logic sel_q;
    logic b2_q;
    logic pz;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            b2_q  <= 1'b0;
        end else if (addr_valid) begin
            sel_q <= cfg_sel_adv;
            b2_q  <= cfg_beat2;
        end
    end

    assign pz = sel_q ? adv_hold : oe_n;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!beat_valid && arr_addr == '0));

    p_beat2_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && b2_q) |=> !beat_valid);

    p_base_const_r7: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |=> $stable(arr_addr[ADDR_W-1:5]));

    p_pause_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!addr_valid && in_beat && pz) |=> (!beat_valid && $stable(arr_addr)));

    p_abort_r11: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> !beat_valid);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_valid  (addr_valid),
    .cfg_sel_adv (cfg_sel_adv),
    .cfg_beat2   (cfg_beat2),
    .adv_hold    (adv_hold),
    .oe_n        (oe_n),
    .in_beat     (in_beat),
    .arr_addr    (arr_addr),
    .beat_valid  (beat_valid)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          addr_valid = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [1:0]    cfg_wrap = 2'd0;
    logic          cfg_ilv = 1'b0;
    logic          cfg_bus16 = 1'b1;
    logic          cfg_lat5 = 1'b0;
    logic          cfg_beat2 = 1'b0;
    logic          cfg_sel_adv = 1'b1;
    logic          adv_hold = 1'b0;
    logic          oe_n = 1'b0;
    logic [AW-1:0] arr_addr;
    logic          beat_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .start_addr(start_addr),
        .cfg_wrap(cfg_wrap), .cfg_ilv(cfg_ilv), .cfg_bus16(cfg_bus16),
        .cfg_lat5(cfg_lat5), .cfg_beat2(cfg_beat2), .cfg_sel_adv(cfg_sel_adv),
        .adv_hold(adv_hold), .oe_n(oe_n), .arr_addr(arr_addr), .beat_valid(beat_valid)
    );

    // start, wrap, ilv, bus16, lat5, beat2, four expected addresses
    localparam logic [85:0] VEC [8] = '{
        {16'h1232, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1232, 16'h1233, 16'h1230, 16'h1231},
        {16'h0041, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0041, 16'h0040, 16'h0043, 16'h0042},
        {16'h0ABF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0ABF, 16'h0ABE, 16'h0ABD, 16'h0ABC},
        {16'h00F6, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h00F6, 16'h00F7, 16'h00F0, 16'h00F1},
        {16'h00F6, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h00F6, 16'h00F7, 16'h00F0, 16'h00F1},
        {16'h0041, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0041, 16'h0042, 16'h0043, 16'h0040},
        {16'h3C1E, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'h3C1E, 16'h3C1F, 16'h3C10, 16'h3C11},
        {16'h7FFD, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 16'h7FFD, 16'h7FFE, 16'h7FFF, 16'h7FE0}
    };
    string vtag [8] = '{"R4", "R5", "R5", "R7", "R6", "R6", "R7", "R7"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [AW-1:0] s, input logic [1:0] w, input logic ilv,
                          input logic b16, input logic l5, input logic b2, input logic sel);
        @(negedge clk);
        start_addr  = s;
        cfg_wrap    = w;
        cfg_ilv     = ilv;
        cfg_bus16   = b16;
        cfg_lat5    = l5;
        cfg_beat2   = b2;
        cfg_sel_adv = sel;
        addr_valid  = 1'b1;
        @(negedge clk);
        addr_valid  = 1'b0;
    endtask

    // returns cycles (1 = current sample) until beat_valid is seen
    task automatic wait_valid(output int n);
        n = 1;
        while (!beat_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int first_n;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(beat_valid), 0);
        chk("R1 reset addr", 32'(arr_addr), 0);
        rst = 1'b0;

        // Table walk: order, wrap, latency and beat spacing
        for (int i = 0; i < 8; i++) begin
            logic [85:0] v;
            int beat;
            int last;
            int lat;
            int per;
            v = VEC[i];
            lat = v[65] ? 5 : 4;
            per = v[64] ? 2 : 1;
            launch(v[85:70], v[69:68], v[67], v[66], v[65], v[64], 1'b1);
            beat = 0;
            last = 0;
            for (int cyc = 1; cyc < 40 && beat < 4; cyc++) begin
                if (beat_valid) begin
                    if (beat == 0)
                        chk($sformatf("R2 first-beat cycle vec%0d", i), 32'(cyc), 32'(lat - 1));
                    else
                        chk($sformatf("R3 beat gap vec%0d", i), 32'(cyc - last), 32'(per));
                    chk($sformatf("%s addr vec%0d beat%0d", vtag[i], i, beat),
                        32'(arr_addr), 32'(v[63 - 16*beat -: 16]));
                    last = cyc;
                    beat++;
                end
                @(negedge clk);
            end
            chk($sformatf("R3 beats seen vec%0d", i), 32'(beat), 4);
        end

        // R8: keeps cycling past one pass in a 4-group
        launch(16'h0511, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        wait_valid(n);
        for (int b = 0; b < 10; b++) begin
            chk($sformatf("R8 continuous valid beat%0d", b), 32'(beat_valid), 1);
            chk($sformatf("R8 wrap addr beat%0d", b), 32'(arr_addr),
                32'(16'h0510 | 16'((1 + b) % 4)));
            @(negedge clk);
        end

        // R9: adv_hold pauses, oe_n ignored
        oe_n = 1'b1;
        launch(16'h0020, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        wait_valid(n);
        chk("R9 first beat with oe_n high", 32'(arr_addr), 32'h20);
        @(negedge clk);
        chk("R9 oe_n ignored valid", 32'(beat_valid), 1);
        chk("R9 oe_n ignored addr", 32'(arr_addr), 32'h21);
        adv_hold = 1'b1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R9 paused valid", 32'(beat_valid), 0);
            chk("R9 paused addr", 32'(arr_addr), 32'h21);
        end
        adv_hold = 1'b0;
        @(negedge clk);
        chk("R9 resume valid", 32'(beat_valid), 1);
        chk("R9 resume addr", 32'(arr_addr), 32'h22);
        oe_n = 1'b0;

        // R10: oe_n pauses, adv_hold ignored
        adv_hold = 1'b1;
        launch(16'h0035, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        wait_valid(n);
        chk("R10 first beat with adv_hold high", 32'(arr_addr), 32'h35);
        @(negedge clk);
        chk("R10 adv_hold ignored addr", 32'(arr_addr), 32'h36);
        oe_n = 1'b1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R10 paused valid", 32'(beat_valid), 0);
            chk("R10 paused addr", 32'(arr_addr), 32'h36);
        end
        oe_n = 1'b0;
        @(negedge clk);
        chk("R10 resume valid", 32'(beat_valid), 1);
        chk("R10 resume addr", 32'(arr_addr), 32'h37);
        adv_hold = 1'b0;

        // R11: restrobe aborts and restarts latency
        launch(16'h0100, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        wait_valid(n);
        @(negedge clk);
        launch(16'h0207, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R11 abort valid low", 32'(beat_valid), 0);
        wait_valid(first_n);
        chk("R11 restart latency", 32'(first_n), 4);
        chk("R11 restart addr", 32'(arr_addr), 32'h0207);

        // R1: reset mid-burst
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-burst reset valid", 32'(beat_valid), 0);
        chk("R1 mid-burst reset addr", 32'(arr_addr), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", 32'(beat_valid), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule